// File: doc/BRIEF.md
# Programmable Audio Clock-Enable and Sample-Strobe Generator

This block runs entirely on a fast master clock and derives from it two enables for a converter core. The first, the internal clock enable, is the master clock divided by a selectable pre-divider (1, 2 or 3) and then by an optional power-saving scale factor (2 or 4). The second, the sample strobe, fires once every 125 or 128 internal clock enables. Every enable is exactly one master-clock cycle wide, so the core stays on one clock domain.

The pre-divider setting is a stored register. It changes only through a write strobe, and a write is accepted only while the power-down input and the clock-off flag are both high. A write of the reserved code is rejected and sets a sticky error flag. The clock-off flag silences every output at once and returns all divider counters to zero, so a restart produces a fully predictable first strobe. A sync enable level is sampled on internal clock enables, and a rising edge seen there produces a one-cycle start pulse for an external alignment sequence.

All control and status pins are plain levels or single-cycle strobes. No data stream passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `audio_clkgen`

## Requirements
- R1: After reset the stored pre-divide code (`div_cur_o`) is 2'b01 (divide by 2) and `div_err_o` is 0.
- R2: With scaling off, `int_ce_o` pulses once every 1, 2 or 3 master clocks for stored codes 2'b00, 2'b01 and 2'b10. Each pulse is one cycle wide.
- R3: `fs_stb_o` pulses on every 125th `int_ce_o` when `ratio_sel_i`=0, or on every 128th when it is 1. It is only ever high together with `int_ce_o`.
- R4: With `scale_en_i`=1, the `int_ce_o` period is multiplied by 2 (`scale_by4_i`=0) or by 4 (`scale_by4_i`=1). With `scale_en_i`=0 the multiplier is 1.
- R5: While `clk_off_i`=1, `int_ce_o`, `fs_stb_o` and `sync_start_o` are all 0.
- R6: After `clk_off_i` falls, the first `int_ce_o` appears on the (N*S)-th master clock and the first `fs_stb_o` on the (N*S*R)-th, where N is the pre-divide, S is the scale and R is the ratio.
- R7: A write (`div_wr_i`=1) with a legal code updates `div_cur_o` on the next edge only if `pdn_i`=1 and `clk_off_i`=1. Otherwise it is ignored.
- R8: A write of code 2'b11 leaves `div_cur_o` unchanged and sets `div_err_o`, which stays set until reset.
- R9: `sync_start_o` is a one-cycle pulse on an `int_ce_o` cycle where `sync_en_i`=1 and `sync_en_i` was 0 at the previous `int_ce_o`. A held level gives no further pulse. The level must return to 0 and then rise again to give another.
- R10: `sync_start_o` and `fs_stb_o` may be high in the same cycle, and neither suppresses the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_i | input | 1 | Power-down indication; required for pre-divide writes |
| clk_off_i | input | 1 | Clock-off flag; stops and clears all dividers |
| div_wr_i | input | 1 | Pre-divide write strobe |
| div_sel_i | input | 2 | Pre-divide code to write (00 /1, 01 /2, 10 /3, 11 reserved) |
| scale_en_i | input | 1 | Power-saving scale enable |
| scale_by4_i | input | 1 | Scale factor select: 0 gives 2, 1 gives 4 |
| ratio_sel_i | input | 1 | Sample ratio select: 0 gives 125, 1 gives 128 |
| sync_en_i | input | 1 | Sync request level |
| int_ce_o | output | 1 | Internal clock enable |
| fs_stb_o | output | 1 | Sample strobe |
| sync_start_o | output | 1 | Sync sequence start pulse |
| div_cur_o | output | 2 | Stored pre-divide code |
| div_err_o | output | 1 | Sticky reserved-code error |

## Verification
The sync start pulse and the sample strobe can land on the same master-clock cycle, because both are qualified by the same internal clock enable. The bench sets divide 1, no scaling and ratio 125. It counts enables up to the one just before the strobe, then raises the sync level so that its first sampling enable is the strobe cycle. That cycle must show both outputs high. A cycle-accurate behavioural model, compared on every clock, also judges every other coincidence, such as a write attempt or a clock-off edge that lands next to a strobe.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef enum logic [1:0] {
    PDIV_1    = 2'b00,
    PDIV_2    = 2'b01,
    PDIV_3    = 2'b10,
    PDIV_RSVD = 2'b11
  } pdiv_e;

  // terminal count (period minus one) of the pre-divider
  function automatic logic [1:0] pdiv_last(pdiv_e c);
    case (c)
      PDIV_1:  return 2'd0;
      PDIV_2:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/acg_div_ctl.sv
module acg_div_ctl
  import acg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [1:0] code_i,
  input  logic       pdn_i,
  input  logic       clk_off_i,
  output pdiv_e      code_o,
  output logic       err_o
);
  pdiv_e code_q;
  logic  err_q;
  logic  safe;

  assign safe = pdn_i && clk_off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= PDIV_2;
      err_q  <= 1'b0;
    end else if (wr_i) begin
      if (code_i == 2'b11)
        err_q <= 1'b1;
      else if (safe)
        code_q <= pdiv_e'(code_i);
    end
  end

  assign code_o = code_q;
  assign err_o  = err_q;

  // R8: reserved code is never stored and always flags
  p_rsvd_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && code_i == 2'b11) |=> ($stable(code_o) && err_o));
  // R8: stored code is always legal
  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_o != PDIV_RSVD);
  // R7: writes outside the safe window do not take effect
  p_write_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !(pdn_i && clk_off_i)) |=> $stable(code_o));
  // R8: sticky flag never falls outside reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

// File: rtl/acg_mod_counter.sv
module acg_mod_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  // >= keeps the counter bounded if the limit drops while running
  assign at_end = (cnt_q >= last_i);
  assign tick_o = adv_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr_i)
      cnt_q <= '0;
    else if (adv_i)
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int RATIO_LO = 125,
  parameter int RATIO_HI = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdn_i,
  input  logic       clk_off_i,
  input  logic       div_wr_i,
  input  logic [1:0] div_sel_i,
  input  logic       scale_en_i,
  input  logic       scale_by4_i,
  input  logic       ratio_sel_i,
  input  logic       sync_en_i,
  output logic       int_ce_o,
  output logic       fs_stb_o,
  output logic       sync_start_o,
  output logic [1:0] div_cur_o,
  output logic       div_err_o
);
  localparam int RMAX = (RATIO_HI > RATIO_LO) ? RATIO_HI : RATIO_LO;
  localparam int RW   = $clog2(RMAX);
  localparam logic [RW-1:0] LO_LAST = RW'(RATIO_LO - 1);
  localparam logic [RW-1:0] HI_LAST = RW'(RATIO_HI - 1);

  pdiv_e      code;
  logic       running;
  logic       pre_tick, ce, fs;
  logic [1:0] scale_last;
  logic       sync_q;

  acg_div_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(div_wr_i), .code_i(div_sel_i),
    .pdn_i(pdn_i), .clk_off_i(clk_off_i), .code_o(code), .err_o(div_err_o)
  );

  assign running    = !clk_off_i;
  assign scale_last = !scale_en_i ? 2'd0 : (scale_by4_i ? 2'd3 : 2'd1);

  acg_mod_counter #(.W(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(clk_off_i), .adv_i(running),
    .last_i(pdiv_last(code)), .tick_o(pre_tick)
  );

  acg_mod_counter #(.W(2)) u_scale (
    .clk(clk), .rst_n(rst_n), .clr_i(clk_off_i), .adv_i(pre_tick),
    .last_i(scale_last), .tick_o(ce)
  );

  acg_mod_counter #(.W(RW)) u_ratio (
    .clk(clk), .rst_n(rst_n), .clr_i(clk_off_i), .adv_i(ce),
    .last_i(ratio_sel_i ? HI_LAST : LO_LAST), .tick_o(fs)
  );

  // sync level sampled on the internal clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sync_q <= 1'b0;
    else if (ce) sync_q <= sync_en_i;
  end

  assign int_ce_o     = ce;
  assign fs_stb_o     = fs;
  assign sync_start_o = ce && sync_en_i && !sync_q;
  assign div_cur_o    = code;

  // R5
  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off_i |-> !(int_ce_o || fs_stb_o || sync_start_o));
  // R3
  p_fs_on_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fs_stb_o |-> int_ce_o);
  // R9
  p_sync_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start_o |=> !sync_start_o);
  // R2: enable is one cycle wide whenever the pre-divide exceeds 1
  p_ce_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ce_o && div_cur_o != 2'b00) |=> !int_ce_o);
endmodule

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pdn = 0, clk_off = 0, div_wr = 0, scale_en = 0, scale_by4 = 0;
  logic ratio_sel = 1, sync_en = 0;
  logic [1:0] div_sel = 0;
  logic int_ce, fs_stb, sync_start, div_err;
  logic [1:0] div_cur;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  audio_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .pdn_i(pdn), .clk_off_i(clk_off),
    .div_wr_i(div_wr), .div_sel_i(div_sel), .scale_en_i(scale_en),
    .scale_by4_i(scale_by4), .ratio_sel_i(ratio_sel), .sync_en_i(sync_en),
    .int_ce_o(int_ce), .fs_stb_o(fs_stb), .sync_start_o(sync_start),
    .div_cur_o(div_cur), .div_err_o(div_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase since restart, evaluated each cycle
  int m_pos = 0, m_div = 1;
  bit m_err = 0, m_sync_last = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_div = 1; m_err = 0; m_sync_last = 0;
    end else begin
      int n, s, r;
      bit e_ce, e_fs, e_sy;
      n = m_div + 1;
      s = scale_en ? (scale_by4 ? 4 : 2) : 1;
      r = ratio_sel ? 128 : 125;
      e_ce = !clk_off && ((m_pos + 1) % (n * s) == 0);
      e_fs = !clk_off && ((m_pos + 1) % (n * s * r) == 0);
      e_sy = e_ce && sync_en && !m_sync_last;
      chk(int_ce == e_ce, "R2 int_ce", int_ce, e_ce);
      chk(fs_stb == e_fs, "R3 fs_stb", fs_stb, e_fs);
      chk(sync_start == e_sy, "R9 sync_start", sync_start, e_sy);
      chk(div_cur == m_div[1:0], "R7 div_cur", div_cur, m_div);
      chk(div_err == m_err, "R8 div_err", div_err, m_err);
      if (e_ce) m_sync_last = sync_en;
      if (div_wr) begin
        if (div_sel == 2'b11) m_err = 1;
        else if (pdn && clk_off) m_div = div_sel;
      end
      m_pos = clk_off ? 0 : m_pos + 1;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic write_div(input logic [1:0] code, input bit p, input bit off);
    tick(); pdn = p; clk_off = off;
    tick(); div_wr = 1; div_sel = code;
    tick(); div_wr = 0;
  endtask

  task automatic measure(input int code, input bit se, input bit s4, input bit rs);
    int cnt, exp;
    write_div(code[1:0], 1, 1);
    scale_en = se; scale_by4 = s4; ratio_sel = rs; pdn = 0;
    tick(); clk_off = 0;
    exp = (code + 1) * (se ? (s4 ? 4 : 2) : 1) * (rs ? 128 : 125);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!fs_stb && cnt < 5000);
    chk(cnt == exp, "R6 first strobe", cnt, exp);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!fs_stb && cnt < 5000);
    chk(cnt == exp, "R2/R3/R4 strobe period", cnt, exp);
    tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    chk(div_cur == 2'b01, "R1 reset div", div_cur, 1);
    chk(div_err == 1'b0, "R1 reset err", div_err, 0);
    tick();

    // every legal combination: R2 R3 R4 R6
    for (int c = 0; c < 3; c++)
      for (int sc = 0; sc < 3; sc++)
        for (int rr = 0; rr < 2; rr++)
          measure(c, sc != 0, sc == 2, rr[0]);

    // R5: clock off silences everything
    clk_off = 1; sync_en = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!int_ce && !fs_stb && !sync_start, "R5 quiet while off",
          {int_ce, fs_stb, sync_start}, 0);
    end
    tick(); sync_en = 0;

    // R7: write ignored while running, and while off without power-down
    write_div(2'b00, 1, 0);
    @(negedge clk);
    chk(div_cur == 2'b10, "R7 write while running", div_cur, 2);
    write_div(2'b01, 0, 1);
    @(negedge clk);
    chk(div_cur == 2'b10, "R7 write without pdn", div_cur, 2);
    write_div(2'b00, 1, 1);
    @(negedge clk);
    chk(div_cur == 2'b00, "R7 write in safe window", div_cur, 0);

    // R8: reserved code
    write_div(2'b11, 1, 1);
    @(negedge clk);
    chk(div_cur == 2'b00, "R8 reserved keeps code", div_cur, 0);
    chk(div_err == 1'b1, "R8 error set", div_err, 1);
    write_div(2'b01, 1, 1);
    @(negedge clk);
    chk(div_err == 1'b1, "R8 error sticky", div_err, 1);
    write_div(2'b00, 1, 1);

    // R9: one pulse per rising edge of the sync level
    scale_en = 0; ratio_sel = 0; pdn = 0;
    tick(); clk_off = 0;
    repeat (5) tick();
    begin
      int pulses = 0;
      sync_en = 1;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (sync_start) pulses++; end
      chk(pulses == 1, "R9 held level single pulse", pulses, 1);
      tick(); sync_en = 0;
      repeat (5) tick();
      sync_en = 1; pulses = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (sync_start) pulses++; end
      chk(pulses == 1, "R9 clear then set repulses", pulses, 1);
      tick(); sync_en = 0;
    end

    // R10: sync pulse on the strobe cycle (divide 1, no scale, ratio 125)
    clk_off = 1;
    repeat (3) tick();
    clk_off = 0;
    repeat (124) @(negedge clk);
    tick(); sync_en = 1;
    @(negedge clk);
    chk(fs_stb && sync_start, "R10 coincident strobe and sync",
        {fs_stb, sync_start}, 3);
    tick(); sync_en = 0;
    repeat (5) tick();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule